// File: doc/BRIEF.md
# Non-Cacheable Address Region Decoder

This block tells an on-chip cache, for any 32-bit physical address, whether a line holding that address may be kept. The answer comes out as one combinational flag, `cacheable`. An address is refused when any of these applies:

- it falls in one of four programmable exclusion windows;
- the legacy option is on and the address lies in the fixed area from 000A0000 to 000FFFFF;
- the boundary option is on and the address lies in the first 64 KB after a 1 MB boundary;
- the global disable input is high.

Each window holds a 20-bit page base, which gives address bits 31:12, and a 4-bit size code. The base is stored rounded down to the window size, so software reads back the base the decoder actually uses. The block also issues a one-cycle flush request when the bus-hold acknowledge rises, if the flush option is set. It also keeps an associativity mode bit for the cache and returns that bit on reads.

Configuration uses a single-cycle write port with a 3-bit index and a 24-bit data word, and a combinational read port that uses the same index map.

Top module: `ncr_decoder`

## Requirements
- R1: Index 0 is the control word. Bit 0 is the legacy-area option, bit 1 is the boundary option, bit 2 is the direct-mapped mode bit and bit 3 is the flush-on-hold option. Bits 23:4 read as zero. Indices 1 to 4 are windows 1 to 4. Their data word is {base[19:0] in bits 23:4, size code in bits 3:0}.
- R2: A window with a size code of 1 to 14 covers 4 KB << (code-1) bytes, starting at its base. Addresses inside it read `cacheable`=0, and addresses just outside it read 1.
- R3: Size code 15 makes every address non-cacheable, and the stored base reads back as zero. Size code 0 makes the window match nothing.
- R4: On a write with codes 1 to 14, the base bits below the window alignment are cleared before they are stored. The read port returns this aligned value.
- R5: With the legacy option set, every address from 000A0000 to 000FFFFF is non-cacheable. 0009FFFF and 00100000 are not affected by this option.
- R6: With the boundary option set, an address whose bits 19:16 are zero is non-cacheable.
- R7: After reset, the control word reads 0, window 1 reads 0x000A06 (128 KB at 000A0000), and windows 2 to 4 read 0.
- R8: With the flush option set, a rise of `hold_ack` makes `flush_req` high for exactly one cycle, on the clock edge after the rise is sampled. With the option clear, `flush_req` stays low.
- R9: The direct-mapped bit is stored and read back. It has no effect on `cacheable`.
- R10: `cache_dis` high forces `cacheable` low for every address.
- R11: Writes to indices 5 to 7 change no state, and those indices read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_idx | input | 3 | Register index for the write |
| wr_data | input | 24 | Write data |
| rd_idx | input | 3 | Register index for the read |
| rd_data | output | 24 | Read data (combinational) |
| addr | input | 32 | Physical address to classify |
| cache_dis | input | 1 | Global cache disable |
| cacheable | output | 1 | High when the address may be cached |
| hold_ack | input | 1 | Bus-hold acknowledge |
| flush_req | output | 1 | One-cycle flush request |

## Verification
The assertions check the following on every cycle:
- the global disable always wins;
- code 15 in any window always excludes the address;
- the legacy range is refused whenever its option is set;
- a flush request lasts a single cycle and always follows a sampled `hold_ack`;
- writes to unused indices leave the control word unchanged.

Only the bench scenarios can show the window edges for the different size codes, the rounding of the base as seen through the read port, and the reset contents. The same holds for the boundary option at several megabyte offsets and for the proof that the mode bit leaves the decode unchanged.

// File: rtl/ncr_pkg.sv
package ncr_pkg;
  localparam int ADDR_W   = 32;
  localparam int PAGE_SH  = 12;
  localparam int PAGE_W   = ADDR_W - PAGE_SH;
  localparam int CODE_W   = 4;
  localparam int DATA_W   = PAGE_W + CODE_W;
  localparam int IDX_W    = 3;
  localparam int N_WIN    = 4;

  localparam logic [CODE_W-1:0] CODE_OFF = '0;
  localparam logic [CODE_W-1:0] CODE_ALL = '1;

  typedef struct packed {
    logic flush_on_hold;
    logic direct_map;
    logic mb_skip;
    logic legacy_skip;
  } ctl_t;

  // Mask of the base bits that take part in the compare for a size code.
  function automatic logic [PAGE_W-1:0] keep_mask(input logic [CODE_W-1:0] code);
    logic [PAGE_W-1:0] m;
    if (code == CODE_OFF)      m = '1;
    else if (code == CODE_ALL) m = '0;
    else                       m = ~((PAGE_W'(1) << (code - CODE_W'(1))) - PAGE_W'(1));
    return m;
  endfunction

  function automatic logic win_hit(input logic [PAGE_W-1:0] page,
                                   input logic [PAGE_W-1:0] base,
                                   input logic [CODE_W-1:0] code);
    logic h;
    if (code == CODE_OFF)      h = 1'b0;
    else if (code == CODE_ALL) h = 1'b1;
    else                       h = (((page ^ base) & keep_mask(code)) == '0);
    return h;
  endfunction

  // Fixed legacy area 000A0000..000FFFFF.
  function automatic logic in_legacy(input logic [ADDR_W-1:0] a);
    return (a[ADDR_W-1:20] == '0) && (a[19:16] >= 4'hA);
  endfunction

  // First 64 KB after each 1 MB boundary.
  function automatic logic in_mb_head(input logic [ADDR_W-1:0] a);
    return a[19:16] == 4'h0;
  endfunction
endpackage

// File: rtl/ncr_cfg_regs.sv
module ncr_cfg_regs
  import ncr_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [IDX_W-1:0]               rd_idx,
  output logic [DATA_W-1:0]              rd_data,
  output ctl_t                           ctl,
  output logic [N_WIN-1:0][PAGE_W-1:0]   win_base,
  output logic [N_WIN-1:0][CODE_W-1:0]   win_code
);
  localparam logic [PAGE_W-1:0] RST_BASE1 = PAGE_W'(20'h000A0);
  localparam logic [CODE_W-1:0] RST_CODE1 = CODE_W'(4'h6);

  logic [CODE_W-1:0] new_code;
  logic [PAGE_W-1:0] new_base;
  assign new_code = wr_data[CODE_W-1:0];
  assign new_base = wr_data[DATA_W-1:CODE_W] & keep_mask(new_code);

  always_ff @(posedge clk) begin
    if (!rst_n) ctl <= '0;
    else if (wr_en && wr_idx == '0) ctl <= ctl_t'(wr_data[3:0]);
  end

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(w + 1);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win_base[w] <= (w == 0) ? RST_BASE1 : '0;
        win_code[w] <= (w == 0) ? RST_CODE1 : '0;
      end else if (wr_en && wr_idx == MY_IDX) begin
        win_base[w] <= new_base;
        win_code[w] <= new_code;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_idx == '0) begin
      rd_data[3:0] = ctl;
    end else begin
      for (int w = 0; w < N_WIN; w++)
        if (rd_idx == IDX_W'(w + 1)) rd_data = {win_base[w], win_code[w]};
    end
  end
endmodule

// File: rtl/ncr_win_match.sv
module ncr_win_match
  import ncr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] base,
  input  logic [CODE_W-1:0] code,
  output logic              hit
);
  assign hit = win_hit(addr[ADDR_W-1:PAGE_SH], base, code);
endmodule

// File: rtl/ncr_hold_flush.sv
module ncr_hold_flush (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic hold_ack,
  output logic flush_req
);
  logic hold_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= 1'b0;
      flush_req <= 1'b0;
    end else begin
      hold_q    <= hold_ack;
      flush_req <= enable && hold_ack && !hold_q;
    end
  end
endmodule

// File: rtl/ncr_decoder.sv
module ncr_decoder
  import ncr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_idx,
  input  logic [23:0]       wr_data,
  input  logic [2:0]        rd_idx,
  output logic [23:0]       rd_data,
  input  logic [31:0]       addr,
  input  logic              cache_dis,
  output logic              cacheable,
  input  logic              hold_ack,
  output logic              flush_req
);
  ctl_t                          ctl;
  logic [N_WIN-1:0][PAGE_W-1:0]  win_base;
  logic [N_WIN-1:0][CODE_W-1:0]  win_code;
  logic [N_WIN-1:0]              win_hits;
  logic                          any_win_hit;
  logic                          legacy_hit;
  logic                          mb_hit;
  logic [3:0]                    ctl_bits;
  logic                          whole_space_off;

  ncr_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .ctl(ctl),
    .win_base(win_base), .win_code(win_code)
  );

  for (genvar w = 0; w < N_WIN; w++) begin : g_match
    ncr_win_match u_m (
      .addr(addr), .base(win_base[w]), .code(win_code[w]), .hit(win_hits[w])
    );
  end

  always_comb begin
    whole_space_off = 1'b0;
    for (int w = 0; w < N_WIN; w++)
      if (win_code[w] == CODE_ALL) whole_space_off = 1'b1;
  end

  assign ctl_bits    = ctl;
  assign any_win_hit = |win_hits;
  assign legacy_hit  = ctl.legacy_skip && in_legacy(addr);
  assign mb_hit      = ctl.mb_skip && in_mb_head(addr);
  assign cacheable   = !cache_dis && !any_win_hit && !legacy_hit && !mb_hit;

  ncr_hold_flush u_flush (
    .clk(clk), .rst_n(rst_n), .enable(ctl.flush_on_hold),
    .hold_ack(hold_ack), .flush_req(flush_req)
  );
endmodule

// File: rtl/ncr_decoder_chk.sv
module ncr_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_idx,
  input logic [31:0] addr,
  input logic        cache_dis,
  input logic        cacheable,
  input logic        hold_ack,
  input logic        flush_req,
  input logic [3:0]  ctl_bits,
  input logic        whole_space_off
);
  assert_global_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cache_dis |-> !cacheable);

  assert_whole_space_R3: assert property (@(posedge clk) disable iff (!rst_n)
    whole_space_off |-> !cacheable);

  assert_legacy_area_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_bits[0] && addr[31:20] == 12'h000 && addr[19:16] >= 4'hA) |-> !cacheable);

  assert_mb_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_bits[1] && addr[19:16] == 4'h0) |-> !cacheable);

  assert_flush_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req);

  assert_flush_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush_req) |-> $past(hold_ack));

  assert_unused_idx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx > 3'd4) |=> $stable(ctl_bits));
endmodule

bind ncr_decoder ncr_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .addr(addr),
  .cache_dis(cache_dis), .cacheable(cacheable), .hold_ack(hold_ack),
  .flush_req(flush_req), .ctl_bits(ctl_bits), .whole_space_off(whole_space_off)
);

// File: tb/ncr_decoder_test.sv
module ncr_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [23:0] wr_data = '0;
  logic [2:0]  rd_idx = '0;
  logic [23:0] rd_data;
  logic [31:0] addr = '0;
  logic        cache_dis = 1'b0;
  logic        cacheable;
  logic        hold_ack = 1'b0;
  logic        flush_req;

  ncr_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .addr(addr), .cache_dis(cache_dis),
    .cacheable(cacheable), .hold_ack(hold_ack), .flush_req(flush_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef enum logic [1:0] {K_CACHE, K_READ, K_FLUSH} kind_t;
  typedef struct {
    kind_t       kind;
    logic [23:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // Monitor: compares queued expectations at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [23:0] act;
        it = q.pop_front();
        case (it.kind)
          K_CACHE: act = {23'd0, cacheable};
          K_READ:  act = rd_data;
          default: act = {23'd0, flush_req};
        endcase
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s actual=%06h expected=%06h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] idx, input logic [23:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic exp_cache(input logic [31:0] a, input logic e, input string tag);
    @(posedge clk); #1;
    addr = a;
    q.push_back('{K_CACHE, {23'd0, e}, tag});
  endtask

  task automatic exp_read(input logic [2:0] idx, input logic [23:0] e, input string tag);
    @(posedge clk); #1;
    rd_idx = idx;
    q.push_back('{K_READ, e, tag});
  endtask

  task automatic exp_flush_seq(input logic en, input string tag);
    @(posedge clk); #1;
    hold_ack = 1'b1;
    @(posedge clk); #1;                       // rise sampled at this edge
    q.push_back('{K_FLUSH, {23'd0, en}, tag});
    @(posedge clk); #1;
    q.push_back('{K_FLUSH, 24'd0, tag});
    @(posedge clk); #1;
    hold_ack = 1'b0;
    q.push_back('{K_FLUSH, 24'd0, tag});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R7 reset contents, R1 index map
    exp_read(3'd0, 24'h000000, "R7 ctl reset");
    exp_read(3'd1, 24'h000A06, "R7 win1 reset");
    exp_read(3'd2, 24'h000000, "R7 win2 reset");
    exp_read(3'd4, 24'h000000, "R7 win4 reset");
    // R2 default window 128 KB at A0000
    exp_cache(32'h000A0000, 1'b0, "R2 win1 low edge");
    exp_cache(32'h000BFFFF, 1'b0, "R2 win1 high edge");
    exp_cache(32'h000C0000, 1'b1, "R2 win1 above");
    exp_cache(32'h0009FFFF, 1'b1, "R2 win1 below");

    // R4 16 KB window, base 12345 rounds to 12344
    wr(3'd2, 24'h123453);
    exp_read(3'd2, 24'h123443, "R4 aligned base readback");
    exp_cache(32'h12344000, 1'b0, "R2 16K low");
    exp_cache(32'h12347FFF, 1'b0, "R2 16K high");
    exp_cache(32'h12348000, 1'b1, "R2 16K above");
    exp_cache(32'h12343FFF, 1'b1, "R2 16K below");

    // R4 32 MB window, base 0A5FF rounds to 0A000
    wr(3'd3, 24'h0A5FFE);
    exp_read(3'd3, 24'h0A000E, "R4 32M readback");
    exp_cache(32'h0A000000, 1'b0, "R2 32M low");
    exp_cache(32'h0BFFFFFF, 1'b0, "R2 32M high");
    exp_cache(32'h0C000000, 1'b1, "R2 32M above");
    exp_cache(32'h09FFFFFF, 1'b1, "R2 32M below");

    // R3 code 0 disables
    wr(3'd2, 24'h123440);
    exp_cache(32'h12344000, 1'b1, "R3 code0 no match");
    wr(3'd3, 24'h000000);

    // R5 legacy area
    wr(3'd0, 24'h000001);
    exp_cache(32'h000D0000, 1'b0, "R5 legacy mid");
    exp_cache(32'h000FFFFF, 1'b0, "R5 legacy top");
    exp_cache(32'h00100000, 1'b1, "R5 legacy above");
    exp_cache(32'h0009FFFF, 1'b1, "R5 legacy below");

    // R6 megabyte heads
    wr(3'd0, 24'h000002);
    exp_cache(32'h00500000, 1'b0, "R6 head start");
    exp_cache(32'h0050FFFF, 1'b0, "R6 head end");
    exp_cache(32'h00510000, 1'b1, "R6 past head");
    exp_cache(32'hFFF0ABCD, 1'b0, "R6 top MB head");
    exp_cache(32'h000D0000, 1'b1, "R5 legacy off");

    // R9 direct-map bit stored, no decode effect
    wr(3'd0, 24'h000004);
    exp_read(3'd0, 24'h000004, "R9 mode readback");
    exp_cache(32'h00C00000, 1'b1, "R9 decode unchanged");
    exp_cache(32'h000A0000, 1'b0, "R9 win1 still active");

    // R3 code F excludes everything
    wr(3'd4, 24'h12345F);
    exp_read(3'd4, 24'h00000F, "R3 codeF base zero");
    exp_cache(32'h80000000, 1'b0, "R3 codeF high addr");
    exp_cache(32'h00000000, 1'b0, "R3 codeF zero addr");
    wr(3'd4, 24'h000000);
    exp_cache(32'h80000000, 1'b1, "R3 codeF removed");

    // R10 global disable
    @(posedge clk); #1 cache_dis = 1'b1;
    exp_cache(32'h00C00000, 1'b0, "R10 disable forces low");
    @(posedge clk); #1 cache_dis = 1'b0;
    exp_cache(32'h00C00000, 1'b1, "R10 released");

    // R11 unused indices
    wr(3'd5, 24'hFFFFFF);
    wr(3'd7, 24'hFFFFFF);
    exp_read(3'd0, 24'h000004, "R11 ctl unchanged");
    exp_read(3'd5, 24'h000000, "R11 idx5 reads zero");
    exp_read(3'd1, 24'h000A06, "R11 win1 unchanged");
    exp_cache(32'h00C00000, 1'b1, "R11 decode unchanged");

    // R8 flush on hold
    exp_flush_seq(1'b0, "R8 flush disabled");
    wr(3'd0, 24'h000008);
    exp_flush_seq(1'b1, "R8 flush pulse");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule